// File: doc/BRIEF.md
# Multi-Channel Completion Mailbox with Shared Interrupt

This block hands finished buffer descriptors back to the host through eight separate notification queues. Every completion carries a descriptor index, an end-of-packet flag and a mailbox number. The descriptor is linked onto the tail of the selected mailbox's list. The list is kept as a next-pointer array indexed by descriptor, with a head pointer, a tail pointer and an empty flag per mailbox. Software takes descriptors off the head with a pop request and gets the answer one cycle later.

Each mailbox has its own interrupt mask bit and mode bit. With mode 0 the mailbox flags an event for every completed buffer. With mode 1 it flags only buffers that end a packet. An event sets that mailbox's pending bit. Pending bits are cleared by a write-one-to-clear acknowledge. The masked pending bits are ORed into a single host interrupt line. Urgent connections can therefore be steered to a mailbox that is serviced separately from bulk traffic.

The host must not append a descriptor that is already linked in any mailbox.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset the interrupt is low, all pending bits are 0, and a pop of any mailbox reports empty.
- R2: Descriptors appended to one mailbox come out of pops on that mailbox in the order they were appended.
- R3: An append or pop on one mailbox leaves the contents and pending bit of every other mailbox unchanged.
- R4: With mode bit 0, every completion appended to a mailbox sets its pending bit.
- R5: With mode bit 1, only completions with the end-of-packet flag set the pending bit. Other completions are still queued.
- R6: `irq` is high exactly when at least one mailbox has both its pending bit and its mask bit at 1.
- R7: An acknowledge clears the pending bits written as 1 and leaves bits written as 0 unchanged. A qualifying event in the same cycle as the acknowledge leaves the bit set.
- R8: An append and a pop on the same mailbox in the same cycle both take effect. This holds when the list holds one entry: the pop returns the old entry and the new descriptor becomes the sole entry.
- R9: A pop on an empty mailbox returns `pop_empty`=1 with `pop_desc`=0. The mailbox stays empty unless an append arrives in that cycle.
- R10: `pop_valid` is high in the cycle after each pop request and only then. Mask, mode and acknowledge writes take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Completion present this cycle |
| cmp_desc | input | DESC_W | Completed descriptor index |
| cmp_eop | input | 1 | Completed buffer ends a packet |
| cmp_mbox | input | MBOX_W | Target mailbox |
| cfg_mask_we | input | 1 | Write whole mask vector |
| cfg_mask_data | input | NUM_MBOX | Mask bits, 1 = interrupt enabled |
| cfg_mode_we | input | 1 | Write whole mode vector |
| cfg_mode_data | input | NUM_MBOX | Mode bits, 1 = end-of-packet only |
| ack_we | input | 1 | Acknowledge strobe |
| ack_data | input | NUM_MBOX | Pending bits to clear |
| pop_req | input | 1 | Pop request |
| pop_mbox | input | MBOX_W | Mailbox to pop |
| pop_valid | output | 1 | Pop response valid |
| pop_empty | output | 1 | Popped mailbox was empty |
| pop_desc | output | DESC_W | Popped descriptor |
| pending_o | output | NUM_MBOX | Pending bits |
| irq | output | 1 | Shared host interrupt |

## Verification
The hardest condition to reach from the ports is a pop and an append on the same mailbox in the very cycle that mailbox holds exactly one descriptor. Here the head, the tail and the empty flag must all move together. A directed sequence builds that case on purpose. A later random phase confines appends and pops to two mailboxes with high activity, so that lists keep draining to one entry while new completions arrive. Each cycle a queue model in the bench predicts the pending bits, the interrupt line and every pop result.

// File: rtl/mbx_pkg.sv
// Package: default dimensions of the completion mailbox block.
// Assumes nothing beyond the power-of-two descriptor space.
package mbx_pkg;
    parameter int unsigned MBX_NUM_DEFAULT  = 8;
    parameter int unsigned MBX_DESC_DEFAULT = 6;
endpackage

// File: rtl/mbx_link_store.sv
// Next-pointer store: one link entry per descriptor, one write port and
// NUM_RD combinational read ports.
// Assumes at most one link write per cycle.
module mbx_link_store #(
    parameter int DESC_W = 6,
    parameter int NUM_RD = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [DESC_W-1:0]              waddr,
    input  logic [DESC_W-1:0]              wdata,
    input  logic [NUM_RD-1:0][DESC_W-1:0]  raddr,
    output logic [NUM_RD-1:0][DESC_W-1:0]  rdata
);
    localparam int DEPTH = 1 << DESC_W;

    logic [DESC_W-1:0] link_q [DEPTH];

    // Link memory update, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) link_q[i] <= '0;
        end else if (we) begin
            link_q[waddr] <= wdata;
        end
    end

    // One read port per mailbox head.
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rdata[g] = link_q[raddr[g]];
    end
endmodule

// File: rtl/mbx_channel.sv
// One mailbox: head/tail/empty list state, pending bit, mask and mode.
// Assumes head_next is the link entry of the current head.
module mbx_channel #(
    parameter int DESC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_en,
    input  logic [DESC_W-1:0] app_desc,
    input  logic              app_eop,
    input  logic              pop_en,
    input  logic [DESC_W-1:0] head_next,
    input  logic              mask_we,
    input  logic              mask_bit,
    input  logic              mode_we,
    input  logic              mode_bit,
    input  logic              ack,
    output logic [DESC_W-1:0] head,
    output logic              empty,
    output logic              pending,
    output logic              irq_req,
    output logic              link_we,
    output logic [DESC_W-1:0] link_addr
);
    logic [DESC_W-1:0] tail;
    logic              mask_q;
    logic              mode_q;
    logic              single;
    logic              qualify;

    assign single    = (head == tail);
    assign qualify   = app_en && (!mode_q || app_eop);
    assign link_we   = app_en && !empty;
    assign link_addr = tail;
    assign irq_req   = pending && mask_q;

    // List pointer update for append, pop, or both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            empty <= 1'b1;
        end else if (empty) begin
            if (app_en) begin
                head  <= app_desc;
                tail  <= app_desc;
                empty <= 1'b0;
            end
        end else begin
            if (app_en) tail <= app_desc;
            if (pop_en) begin
                if (single) begin
                    if (app_en) head <= app_desc;
                    else        empty <= 1'b1;
                end else begin
                    head <= head_next;
                end
            end
        end
    end

    // Pending bit: a new event wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= qualify || (pending && !ack);
    end

    // Mask and mode configuration bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            if (mask_we) mask_q <= mask_bit;
            if (mode_we) mode_q <= mode_bit;
        end
    end

    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(pending) |-> $past(app_en)); // R4
    AST_EOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(pending) && $past(mode_q) |-> $past(app_eop)); // R5
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ack && !app_en) |-> !pending); // R7
    AST_ONE_ENTRY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(pop_en && app_en && !empty && single)
        |-> !empty && head == $past(app_desc)); // R8
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(pop_en && empty && !app_en) |-> empty); // R9
endmodule

// File: rtl/mbx_irq_ctrl.sv
// Top: routes completions and pops to the mailboxes, shares one link
// store, registers pop responses and ORs the masked pending bits.
// Assumes a descriptor is linked in at most one mailbox at a time.
module mbx_irq_ctrl #(
    parameter int NUM_MBOX = mbx_pkg::MBX_NUM_DEFAULT,
    parameter int DESC_W   = mbx_pkg::MBX_DESC_DEFAULT,
    localparam int MBOX_W  = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_valid,
    input  logic [DESC_W-1:0]   cmp_desc,
    input  logic                cmp_eop,
    input  logic [MBOX_W-1:0]   cmp_mbox,
    input  logic                cfg_mask_we,
    input  logic [NUM_MBOX-1:0] cfg_mask_data,
    input  logic                cfg_mode_we,
    input  logic [NUM_MBOX-1:0] cfg_mode_data,
    input  logic                ack_we,
    input  logic [NUM_MBOX-1:0] ack_data,
    input  logic                pop_req,
    input  logic [MBOX_W-1:0]   pop_mbox,
    output logic                pop_valid,
    output logic                pop_empty,
    output logic [DESC_W-1:0]   pop_desc,
    output logic [NUM_MBOX-1:0] pending_o,
    output logic                irq
);
    logic [NUM_MBOX-1:0][DESC_W-1:0] head;
    logic [NUM_MBOX-1:0][DESC_W-1:0] head_next;
    logic [NUM_MBOX-1:0][DESC_W-1:0] link_addr;
    logic [NUM_MBOX-1:0]             empty;
    logic [NUM_MBOX-1:0]             irq_req;
    logic [NUM_MBOX-1:0]             link_we;
    logic                            st_we;
    logic [DESC_W-1:0]               st_waddr;

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_ch
        mbx_channel #(.DESC_W(DESC_W)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .app_en    (cmp_valid && cmp_mbox == MBOX_W'(g)),
            .app_desc  (cmp_desc),
            .app_eop   (cmp_eop),
            .pop_en    (pop_req && pop_mbox == MBOX_W'(g)),
            .head_next (head_next[g]),
            .mask_we   (cfg_mask_we),
            .mask_bit  (cfg_mask_data[g]),
            .mode_we   (cfg_mode_we),
            .mode_bit  (cfg_mode_data[g]),
            .ack       (ack_we && ack_data[g]),
            .head      (head[g]),
            .empty     (empty[g]),
            .pending   (pending_o[g]),
            .irq_req   (irq_req[g]),
            .link_we   (link_we[g]),
            .link_addr (link_addr[g])
        );
    end

    // Merge the single active link write request from the channels.
    always_comb begin
        st_we    = 1'b0;
        st_waddr = '0;
        for (int i = 0; i < NUM_MBOX; i++) begin
            st_we    = st_we | link_we[i];
            st_waddr = st_waddr | (link_we[i] ? link_addr[i] : '0);
        end
    end

    mbx_link_store #(.DESC_W(DESC_W), .NUM_RD(NUM_MBOX)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (cmp_desc),
        .raddr (head),
        .rdata (head_next)
    );

    // Registered pop response, sampled before the list moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid <= 1'b0;
            pop_empty <= 1'b0;
            pop_desc  <= '0;
        end else begin
            pop_valid <= pop_req;
            pop_empty <= empty[pop_mbox];
            pop_desc  <= empty[pop_mbox] ? '0 : head[pop_mbox];
        end
    end

    assign irq = |irq_req;

    AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pop_valid == $past(pop_req)); // R10
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pending_o != '0); // R6
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid && pop_empty |-> pop_desc == '0); // R9
endmodule

// File: tb/mbx_irq_ctrl_tb.sv
module mbx_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NM = 8;
    localparam int DW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_valid = 0, cmp_eop = 0;
    logic [DW-1:0] cmp_desc = '0;
    logic [2:0] cmp_mbox = '0, pop_mbox = '0;
    logic cfg_mask_we = 0, cfg_mode_we = 0, ack_we = 0, pop_req = 0;
    logic [NM-1:0] cfg_mask_data = '0, cfg_mode_data = '0, ack_data = '0;
    logic pop_valid, pop_empty, irq;
    logic [DW-1:0] pop_desc;
    logic [NM-1:0] pending_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_desc(cmp_desc),
        .cmp_eop(cmp_eop), .cmp_mbox(cmp_mbox), .cfg_mask_we(cfg_mask_we),
        .cfg_mask_data(cfg_mask_data), .cfg_mode_we(cfg_mode_we),
        .cfg_mode_data(cfg_mode_data), .ack_we(ack_we), .ack_data(ack_data),
        .pop_req(pop_req), .pop_mbox(pop_mbox), .pop_valid(pop_valid),
        .pop_empty(pop_empty), .pop_desc(pop_desc), .pending_o(pending_o), .irq(irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] mq [NM][$];
    logic [DW-1:0] free_q [$];
    logic [NM-1:0] m_pend = '0, m_mask = '0, m_mode = '0;
    logic exp_pv = 0, exp_pe = 0;
    logic [DW-1:0] exp_pd = '0;
    string pop_tag = "R2";
    string pend_tag = "R4 R5 R7";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(m_pend & m_mask);
    endfunction

    // One cycle: drive inputs, advance the model, check at the next negedge.
    task automatic step(input bit a_v, input int a_m, input bit a_e,
                        input bit p_v, input int p_m,
                        input bit mk_we, input logic [NM-1:0] mk,
                        input bit mo_we, input logic [NM-1:0] mo,
                        input bit ak_we, input logic [NM-1:0] ak);
        logic [DW-1:0] d = '0;
        logic [NM-1:0] qual = '0;
        bit av = a_v && free_q.size() != 0;
        if (av) d = free_q.pop_front();
        cmp_valid = av; cmp_desc = d; cmp_eop = a_e; cmp_mbox = 3'(a_m);
        pop_req = p_v; pop_mbox = 3'(p_m);
        cfg_mask_we = mk_we; cfg_mask_data = mk;
        cfg_mode_we = mo_we; cfg_mode_data = mo;
        ack_we = ak_we; ack_data = ak;
        exp_pv = p_v;
        if (p_v) begin
            if (mq[p_m].size() == 0) begin exp_pe = 1; exp_pd = '0; end
            else begin exp_pe = 0; exp_pd = mq[p_m].pop_front(); free_q.push_back(exp_pd); end
        end
        if (av) begin
            mq[a_m].push_back(d);
            if (!m_mode[a_m] || a_e) qual[a_m] = 1'b1;
        end
        m_pend = qual | (m_pend & ~(ak_we ? ak : '0));
        if (mk_we) m_mask = mk;
        if (mo_we) m_mode = mo;
        @(negedge clk);
        chk("R10", pop_valid, exp_pv);
        if (exp_pv) begin
            chk(exp_pe ? "R9" : pop_tag, pop_empty, exp_pe);
            chk(exp_pe ? "R9" : pop_tag, pop_desc, exp_pd);
        end
        chk(pend_tag, pending_o, m_pend);
        chk("R6", irq, exp_irq());
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, '0, 0, '0, 0, '0);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5eed_1234);
        for (int i = 0; i < (1 << DW); i++) free_q.push_back(DW'(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", irq, 0);
        chk("R1", pending_o, 0);
        for (int m = 0; m < NM; m++) begin
            step(0, 0, 0, 1, m, 0, '0, 0, '0, 0, '0);
            chk("R1", pop_empty, 1);
        end
        // R2: ordering on one mailbox, masked pending does not raise irq (R6)
        pop_tag = "R2";
        for (int k = 0; k < 4; k++) step(1, 2, 0, 0, 0, 0, '0, 0, '0, 0, '0);
        chk("R6", irq, 0);
        // R3: other mailbox unaffected
        step(0, 0, 0, 1, 5, 0, '0, 0, '0, 0, '0);
        chk("R3", pop_empty, 1);
        chk("R3", pending_o[5], 0);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 2, 0, '0, 0, '0, 0, '0);
        // R6: enable mask
        step(0, 0, 0, 0, 0, 1, 8'h04, 0, '0, 0, '0);
        chk("R6", irq, 1);
        // R7: ack clears only written bit; set wins over same-cycle ack
        step(1, 3, 0, 0, 0, 0, '0, 0, '0, 1, 8'h00);
        pend_tag = "R7";
        step(0, 0, 0, 0, 0, 0, '0, 0, '0, 1, 8'h04);
        chk("R7", pending_o, 8'h08);
        step(1, 3, 0, 0, 0, 0, '0, 0, '0, 1, 8'h08);
        chk("R7", pending_o[3], 1);
        step(0, 0, 0, 0, 0, 0, '0, 0, '0, 1, 8'hFF);
        // R5: end-of-packet-only mode on mailbox 1
        pend_tag = "R5";
        step(0, 0, 0, 0, 0, 0, '0, 1, 8'h02, 0, '0);
        step(1, 1, 0, 0, 0, 0, '0, 0, '0, 0, '0);
        chk("R5", pending_o[1], 0);
        step(1, 1, 1, 0, 0, 0, '0, 0, '0, 0, '0);
        chk("R5", pending_o[1], 1);
        pend_tag = "R4";
        step(1, 0, 0, 0, 0, 0, '0, 0, '0, 0, '0);
        chk("R4", pending_o[0], 1);
        // R8: one-entry list, append and pop same cycle
        pop_tag = "R8";
        step(1, 4, 0, 0, 0, 0, '0, 0, '0, 0, '0);
        step(1, 4, 0, 1, 4, 0, '0, 0, '0, 0, '0);
        chk("R8", pop_empty, 0);
        step(0, 0, 0, 1, 4, 0, '0, 0, '0, 0, '0);
        chk("R8", pop_empty, 0);
        step(0, 0, 0, 1, 4, 0, '0, 0, '0, 0, '0);
        chk("R8", pop_empty, 1);
        // Random phase: all mailboxes, then two busy mailboxes
        pend_tag = "R4 R5 R7";
        for (int c = 0; c < 4000; c++) begin
            int nm = (c < 2000) ? NM : 2;
            pop_tag = (c < 2000) ? "R2" : "R8";
            step($urandom % 3 != 0, int'($urandom % nm), $urandom % 2 == 1,
                 $urandom % 2 == 1, int'($urandom % nm),
                 $urandom % 16 == 0, NM'($urandom),
                 $urandom % 32 == 0, NM'($urandom),
                 $urandom % 4 == 0, NM'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule